// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block holds the 32-bit interrupt status word of a USB device controller. The endpoint engines send single-cycle event pulses: a byte count that ran out, a skip request, a received SETUP packet, a NAK that was sent, or an active flag that hardware cleared. The block qualifies each pulse against its own set conditions and latches the result into one sticky bit per endpoint direction. The bits cover the control endpoint and a parameterised number of generic endpoints (four by default). Two more bits are fed differently. A frame flag comes from a built-in millisecond prescaler that runs only while VBUS is valid and the device is connected. A device-change flag is raised by any bit of a device-status-change vector.

Software reads the word through a plain read/write port and clears bits by writing ones to them. A single interrupt line is high while any status bit is set. Interrupt masking, packet handling and the endpoint engines sit outside this block.

Top module: `usbd_int_status`

## Requirements
- R1: After reset the status word reads 0x00000000 and `irq_o` is low.
- R2: Only bits 0, 1, 2..(1+2*N_GEN), 30 and 31 are implemented. With N_GEN=4, bits 10..29 always read as zero, even after writes or events.
- R3: Bit 0 (control OUT) sets one cycle after a pulse on `ctl_out_zero_i`, `ctl_out_skip_i` or `ctl_setup_i`.
- R4: Bit 1 (control IN) sets one cycle after a pulse on `ctl_in_zero_i` or `ctl_in_skip_i`. A SETUP pulse never sets bit 1.
- R5: For generic endpoint k (1..N_GEN), a pulse on `gen_out_done_i[k-1]` sets bit 2k, and a pulse on `gen_in_done_i[k-1]` sets bit 2k+1.
- R6: A NAK pulse sets its endpoint's bit only while the enable for its class is high. The four classes are control OUT, control IN, generic OUT and generic IN, each with its own enable.
- R7: Every implemented bit stays set after its event ends, until software clears it.
- R8: A register write clears every bit whose write-data bit is one. Bits written as zero keep their value.
- R9: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R10: The frame bit (30) sets after TICK_CYCLES consecutive clocks with both `vbus_ok_i` and `connected_i` high, and again every TICK_CYCLES clocks after that. It never sets while either input is low. A drop of either input restarts the count from zero.
- R11: The device bit (31) sets one cycle after any bit of `devchg_i` is high.
- R12: `irq_o` is high exactly when the status word is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_out_zero_i | input | 1 | Control OUT byte count reached zero (pulse) |
| ctl_out_skip_i | input | 1 | Control OUT skip requested (pulse) |
| ctl_setup_i | input | 1 | SETUP packet received successfully (pulse) |
| ctl_out_nak_i | input | 1 | NAK sent on control OUT (pulse) |
| ctl_in_zero_i | input | 1 | Control IN byte count reached zero (pulse) |
| ctl_in_skip_i | input | 1 | Control IN skip requested (pulse) |
| ctl_in_nak_i | input | 1 | NAK sent on control IN (pulse) |
| gen_out_done_i | input | N_GEN | Generic OUT active flag cleared by hardware, one per endpoint (pulse) |
| gen_in_done_i | input | N_GEN | Generic IN active flag cleared by hardware, one per endpoint (pulse) |
| gen_out_nak_i | input | N_GEN | NAK sent on a generic OUT endpoint (pulse) |
| gen_in_nak_i | input | N_GEN | NAK sent on a generic IN endpoint (pulse) |
| nak_en_ctl_out_i | input | 1 | NAK events count for control OUT |
| nak_en_ctl_in_i | input | 1 | NAK events count for control IN |
| nak_en_gen_out_i | input | 1 | NAK events count for generic OUT endpoints |
| nak_en_gen_in_i | input | 1 | NAK events count for generic IN endpoints |
| vbus_ok_i | input | 1 | Debounced VBUS valid |
| connected_i | input | 1 | Device connected |
| devchg_i | input | DEVCHG_W | Device-status-change flags |
| reg_wr_i | input | 1 | Write strobe for the status word |
| reg_wdata_i | input | 32 | Write data; a one clears that bit |
| reg_rdata_o | output | 32 | Current status word |
| irq_o | output | 1 | High while any status bit is set |

## Verification
Each event pulse and each write is applied for one cycle. Its effect is due on `reg_rdata_o` one clock later, and `irq_o` follows in that same cycle because it is decoded straight from the register. The frame bit is the exception: it is due TICK_CYCLES clocks after the connect gate rises. The bench checks this by expecting zero for every cycle before that and the flag in exactly that cycle, both for the first gate rise and for the rise that follows a mid-count drop. For every stimulus cycle the driver queues the value due after the next rising edge. The monitor pops one item per edge and compares it a moment after that edge, so each comparison lands in the cycle in which the result is due.

// File: rtl/usbd_ists_pkg.sv
package usbd_ists_pkg;

    localparam int REG_W        = 32;
    localparam int CTL_OUT_BIT  = 0;
    localparam int CTL_IN_BIT   = 1;
    localparam int GEN_BASE_BIT = 2;
    localparam int FRAME_BIT    = 30;
    localparam int DEV_BIT      = 31;
    localparam int MAX_GEN      = (FRAME_BIT - GEN_BASE_BIT) / 2;

    typedef struct packed {
        logic [REG_W-1:0] stat;
    } ists_state_t;

    // Mask of the bits that exist for a given generic endpoint count
    function automatic logic [REG_W-1:0] impl_mask(input int n_gen);
        logic [REG_W-1:0] m;
        m = '0;
        m[CTL_OUT_BIT] = 1'b1;
        m[CTL_IN_BIT]  = 1'b1;
        for (int i = 0; i < 2 * n_gen; i++) begin
            m[GEN_BASE_BIT + i] = 1'b1;
        end
        m[FRAME_BIT] = 1'b1;
        m[DEV_BIT]   = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/usbd_frame_tick.sv
module usbd_frame_tick #(
    parameter int TICK_CYCLES = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vbus_ok_i,
    input  logic connected_i,
    output logic tick_o
);

    localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ft_state_t;

    ft_state_t ft_d, ft_q;
    logic      gate;

    assign gate = vbus_ok_i & connected_i;

    always_comb begin
        ft_d   = ft_q;
        tick_o = 1'b0;
        if (!gate) begin
            ft_d.cnt = '0;
        end else if (ft_q.cnt == LAST) begin
            ft_d.cnt = '0;
            tick_o   = 1'b1;
        end else begin
            ft_d.cnt = ft_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ft_q <= '0;
        end else begin
            ft_q <= ft_d;
        end
    end

endmodule

// File: rtl/usbd_ists_qual.sv
module usbd_ists_qual
    import usbd_ists_pkg::*;
#(
    parameter int N_GEN = 4
) (
    input  logic             ctl_out_zero_i,
    input  logic             ctl_out_skip_i,
    input  logic             ctl_setup_i,
    input  logic             ctl_out_nak_i,
    input  logic             ctl_in_zero_i,
    input  logic             ctl_in_skip_i,
    input  logic             ctl_in_nak_i,
    input  logic [N_GEN-1:0] gen_out_done_i,
    input  logic [N_GEN-1:0] gen_in_done_i,
    input  logic [N_GEN-1:0] gen_out_nak_i,
    input  logic [N_GEN-1:0] gen_in_nak_i,
    input  logic             nak_en_ctl_out_i,
    input  logic             nak_en_ctl_in_i,
    input  logic             nak_en_gen_out_i,
    input  logic             nak_en_gen_in_i,
    input  logic             frame_tick_i,
    input  logic             dev_any_i,
    output logic [REG_W-1:0] set_o
);

    logic [N_GEN-1:0] out_hit;
    logic [N_GEN-1:0] in_hit;

    // Per-endpoint qualification: completion, or NAK gated by its class enable
    for (genvar g = 0; g < N_GEN; g++) begin : g_ep
        assign out_hit[g] = gen_out_done_i[g] | (gen_out_nak_i[g] & nak_en_gen_out_i);
        assign in_hit[g]  = gen_in_done_i[g]  | (gen_in_nak_i[g]  & nak_en_gen_in_i);
    end

    always_comb begin
        set_o = '0;
        set_o[CTL_OUT_BIT] = ctl_out_zero_i | ctl_out_skip_i | ctl_setup_i
                           | (ctl_out_nak_i & nak_en_ctl_out_i);
        set_o[CTL_IN_BIT]  = ctl_in_zero_i | ctl_in_skip_i
                           | (ctl_in_nak_i & nak_en_ctl_in_i);
        for (int i = 0; i < N_GEN; i++) begin
            set_o[GEN_BASE_BIT + 2*i]     = out_hit[i];
            set_o[GEN_BASE_BIT + 2*i + 1] = in_hit[i];
        end
        set_o[FRAME_BIT] = frame_tick_i;
        set_o[DEV_BIT]   = dev_any_i;
    end

endmodule

// File: rtl/usbd_int_status.sv
module usbd_int_status
    import usbd_ists_pkg::*;
#(
    parameter int N_GEN       = 4,
    parameter int TICK_CYCLES = 48000,
    parameter int DEVCHG_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_out_zero_i,
    input  logic                ctl_out_skip_i,
    input  logic                ctl_setup_i,
    input  logic                ctl_out_nak_i,
    input  logic                ctl_in_zero_i,
    input  logic                ctl_in_skip_i,
    input  logic                ctl_in_nak_i,
    input  logic [N_GEN-1:0]    gen_out_done_i,
    input  logic [N_GEN-1:0]    gen_in_done_i,
    input  logic [N_GEN-1:0]    gen_out_nak_i,
    input  logic [N_GEN-1:0]    gen_in_nak_i,
    input  logic                nak_en_ctl_out_i,
    input  logic                nak_en_ctl_in_i,
    input  logic                nak_en_gen_out_i,
    input  logic                nak_en_gen_in_i,
    input  logic                vbus_ok_i,
    input  logic                connected_i,
    input  logic [DEVCHG_W-1:0] devchg_i,
    input  logic                reg_wr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                irq_o
);

    localparam logic [REG_W-1:0] IMPL_MASK = impl_mask(N_GEN);

    ists_state_t      st_d, st_q;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic             frame_tick;

    usbd_frame_tick #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .vbus_ok_i   (vbus_ok_i),
        .connected_i (connected_i),
        .tick_o      (frame_tick)
    );

    usbd_ists_qual #(
        .N_GEN (N_GEN)
    ) u_qual (
        .ctl_out_zero_i   (ctl_out_zero_i),
        .ctl_out_skip_i   (ctl_out_skip_i),
        .ctl_setup_i      (ctl_setup_i),
        .ctl_out_nak_i    (ctl_out_nak_i),
        .ctl_in_zero_i    (ctl_in_zero_i),
        .ctl_in_skip_i    (ctl_in_skip_i),
        .ctl_in_nak_i     (ctl_in_nak_i),
        .gen_out_done_i   (gen_out_done_i),
        .gen_in_done_i    (gen_in_done_i),
        .gen_out_nak_i    (gen_out_nak_i),
        .gen_in_nak_i     (gen_in_nak_i),
        .nak_en_ctl_out_i (nak_en_ctl_out_i),
        .nak_en_ctl_in_i  (nak_en_ctl_in_i),
        .nak_en_gen_out_i (nak_en_gen_out_i),
        .nak_en_gen_in_i  (nak_en_gen_in_i),
        .frame_tick_i     (frame_tick),
        .dev_any_i        (|devchg_i),
        .set_o            (set_vec)
    );

    assign clr_vec = reg_wr_i ? reg_wdata_i : '0;

    // Clear first, then OR the set events so a simultaneous event survives
    always_comb begin
        st_d      = st_q;
        st_d.stat = ((st_q.stat & ~clr_vec) | set_vec) & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata_o = st_q.stat;
    assign irq_o       = |st_q.stat;

endmodule

// File: rtl/usbd_int_status_chk.sv
module usbd_int_status_chk #(
    parameter int DEVCHG_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr_i,
    input logic [31:0]         reg_wdata_i,
    input logic [31:0]         reg_rdata_o,
    input logic                irq_o,
    input logic [31:0]         set_vec,
    input logic                vbus_ok_i,
    input logic                connected_i,
    input logic [DEVCHG_W-1:0] devchg_i
);

    logic [31:0] clr_req;
    assign clr_req = reg_wr_i ? reg_wdata_i : 32'd0;

    // R2
    gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[29:10] == 20'd0);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(reg_rdata_o) & ~$past(clr_req)) & ~reg_rdata_o) == 32'd0));

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_i |=> ((reg_rdata_o & $past(reg_wdata_i & ~set_vec)) == 32'd0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != 32'd0) |=> ((reg_rdata_o & $past(set_vec)) == $past(set_vec)));

    // R10
    frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata_o[30]) |-> $past(vbus_ok_i && connected_i));

    // R11
    dev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|devchg_i) |=> reg_rdata_o[31]);

    // R12
    irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (reg_rdata_o != 32'd0));

endmodule

bind usbd_int_status usbd_int_status_chk #(
    .DEVCHG_W (DEVCHG_W)
) u_ists_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .set_vec     (set_vec),
    .vbus_ok_i   (vbus_ok_i),
    .connected_i (connected_i),
    .devchg_i    (devchg_i)
);

// File: tb/test_usbd_int_status.sv
module test_usbd_int_status;

    localparam int CLK_PERIOD = 10;
    localparam int TICK       = 10;
    localparam int NG         = 4;
    localparam int DW         = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          ctl_out_zero, ctl_out_skip, ctl_setup, ctl_out_nak;
    logic          ctl_in_zero, ctl_in_skip, ctl_in_nak;
    logic [NG-1:0] gen_out_done, gen_in_done, gen_out_nak, gen_in_nak;
    logic [3:0]    nak_en;
    logic          vbus_ok, connected;
    logic [DW-1:0] devchg;
    logic          reg_wr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          irq;

    // Staging for the next driven cycle; pulses clear after use, levels persist
    logic [6:0]    s_ctl = '0;
    logic [NG-1:0] s_gout = '0, s_gin = '0, s_gonak = '0, s_ginak = '0;
    logic [3:0]    s_en = '0;
    logic          s_vbus = 1'b1, s_conn = 1'b0;
    logic [DW-1:0] s_dev = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbd_int_status #(
        .N_GEN       (NG),
        .TICK_CYCLES (TICK),
        .DEVCHG_W    (DW)
    ) i_usbd_int_status (
        .clk              (clk),
        .rst_n            (rst_n),
        .ctl_out_zero_i   (ctl_out_zero),
        .ctl_out_skip_i   (ctl_out_skip),
        .ctl_setup_i      (ctl_setup),
        .ctl_out_nak_i    (ctl_out_nak),
        .ctl_in_zero_i    (ctl_in_zero),
        .ctl_in_skip_i    (ctl_in_skip),
        .ctl_in_nak_i     (ctl_in_nak),
        .gen_out_done_i   (gen_out_done),
        .gen_in_done_i    (gen_in_done),
        .gen_out_nak_i    (gen_out_nak),
        .gen_in_nak_i     (gen_in_nak),
        .nak_en_ctl_out_i (nak_en[0]),
        .nak_en_ctl_in_i  (nak_en[1]),
        .nak_en_gen_out_i (nak_en[2]),
        .nak_en_gen_in_i  (nak_en[3]),
        .vbus_ok_i        (vbus_ok),
        .connected_i      (connected),
        .devchg_i         (devchg),
        .reg_wr_i         (reg_wr),
        .reg_wdata_i      (reg_wdata),
        .reg_rdata_o      (reg_rdata),
        .irq_o            (irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the value due after the next edge
    task automatic cyc(input logic wr, input logic [31:0] wd, input logic [31:0] exp, input string tag);
        @(negedge clk);
        {ctl_in_nak, ctl_in_skip, ctl_in_zero, ctl_out_nak, ctl_setup, ctl_out_skip, ctl_out_zero} = s_ctl;
        gen_out_done = s_gout;
        gen_in_done  = s_gin;
        gen_out_nak  = s_gonak;
        gen_in_nak   = s_ginak;
        nak_en       = s_en;
        vbus_ok      = s_vbus;
        connected    = s_conn;
        devchg       = s_dev;
        reg_wr       = wr;
        reg_wdata    = wd;
        s_ctl = '0; s_gout = '0; s_gin = '0; s_gonak = '0; s_ginak = '0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: one queued item per rising edge, compared just after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(reg_rdata === e, t, reg_rdata, e);
                chk(irq === (e != 32'd0), {t, "/R12 irq"}, {31'd0, irq}, {31'd0, (e != 32'd0)});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        {ctl_in_nak, ctl_in_skip, ctl_in_zero, ctl_out_nak, ctl_setup, ctl_out_skip, ctl_out_zero} = '0;
        gen_out_done = '0; gen_in_done = '0; gen_out_nak = '0; gen_in_nak = '0;
        nak_en = '0; vbus_ok = 1'b1; connected = 1'b0; devchg = '0;
        reg_wr = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R1: reset state
        chk(reg_rdata === 32'd0, "R1 reset word", reg_rdata, 32'd0);
        chk(irq === 1'b0, "R1 reset irq", {31'd0, irq}, 32'd0);

        // R3: control OUT set sources; R7 sticky; R8 clear
        s_ctl[0] = 1'b1; cyc(0, 0, 32'h1, "R3 ctl out zero");
        cyc(0, 0, 32'h1, "R7 sticky after pulse");
        cyc(1, 32'h1, 32'h0, "R8 w1c bit0");
        s_ctl[1] = 1'b1; cyc(0, 0, 32'h1, "R3 ctl out skip");
        cyc(1, 32'h1, 32'h0, "R8 clear");
        // R4: SETUP sets bit 0 only, never bit 1
        s_ctl[2] = 1'b1; cyc(0, 0, 32'h1, "R3/R4 setup sets only bit0");
        cyc(1, 32'h1, 32'h0, "R8 clear");
        s_ctl[4] = 1'b1; cyc(0, 0, 32'h2, "R4 ctl in zero");
        cyc(1, 32'h2, 32'h0, "R8 clear");
        s_ctl[5] = 1'b1; cyc(0, 0, 32'h2, "R4 ctl in skip");
        cyc(0, 0, 32'h2, "R7 sticky bit1");
        cyc(1, 32'h2, 32'h0, "R8 clear");

        // R5: generic endpoints, bit 2k OUT and 2k+1 IN
        begin
            logic [31:0] acc;
            acc = 32'd0;
            for (int k = 1; k <= NG; k++) begin
                s_gout[k-1] = 1'b1;
                acc = acc | (32'h1 << (2*k));
                cyc(0, 0, acc, $sformatf("R5 ep%0d out", k));
                s_gin[k-1] = 1'b1;
                acc = acc | (32'h1 << (2*k+1));
                cyc(0, 0, acc, $sformatf("R5 ep%0d in", k));
            end
        end
        cyc(1, 32'h0, 32'h3FC, "R8 write zero no effect");
        cyc(1, 32'hFFFF_FFFF, 32'h0, "R8/R2 clear all");

        // R6: NAK gating by class enable
        s_ctl[3] = 1'b1; s_ctl[6] = 1'b1; s_gonak = '1; s_ginak = '1;
        cyc(0, 0, 32'h0, "R6 nak with enables off");
        s_en = 4'b0001;
        s_ctl[3] = 1'b1; s_ctl[6] = 1'b1; s_gonak = '1; s_ginak = '1;
        cyc(0, 0, 32'h1, "R6 ctl out enable");
        s_en = 4'b0010;
        s_ctl[3] = 1'b1; s_ctl[6] = 1'b1; s_gonak = '1; s_ginak = '1;
        cyc(0, 0, 32'h3, "R6 ctl in enable");
        s_en = 4'b0100;
        s_ctl[3] = 1'b1; s_ctl[6] = 1'b1; s_gonak = '1; s_ginak = '1;
        cyc(0, 0, 32'h157, "R6 gen out enable");
        s_en = 4'b1000;
        s_ctl[3] = 1'b1; s_ctl[6] = 1'b1; s_gonak = '1; s_ginak = '1;
        cyc(0, 0, 32'h3FF, "R6 gen in enable");
        s_en = 4'b0000;
        cyc(1, 32'h3FF, 32'h0, "R8 clear");

        // R9: set beats simultaneous clear
        s_ctl[0] = 1'b1; cyc(0, 0, 32'h1, "R3 setup for R9");
        s_ctl[0] = 1'b1; cyc(1, 32'h1, 32'h1, "R9 set wins");
        cyc(1, 32'h1, 32'h0, "R8 clear");

        // R11: device change
        s_dev = 5'b00100; cyc(0, 0, 32'h8000_0000, "R11 dev bit");
        s_dev = '0; cyc(0, 0, 32'h8000_0000, "R11 dev sticky");
        cyc(1, 32'h8000_0000, 32'h0, "R8 clear dev");

        // R10: frame tick gating, period and restart
        for (int j = 0; j < 15; j++) cyc(0, 0, 32'h0, "R10 no tick while disconnected");
        s_conn = 1'b1;
        for (int j = 1; j < TICK; j++) cyc(0, 0, 32'h0, "R10 before first tick");
        cyc(0, 0, 32'h4000_0000, "R10 first tick");
        cyc(1, 32'h4000_0000, 32'h0, "R8 clear frame");
        for (int j = 0; j < 3; j++) cyc(0, 0, 32'h0, "R10 mid count");
        s_conn = 1'b0; cyc(0, 0, 32'h0, "R10 gate drop");
        s_conn = 1'b1;
        for (int j = 1; j < TICK; j++) cyc(0, 0, 32'h0, "R10 count restarted");
        cyc(0, 0, 32'h4000_0000, "R10 tick after restart");
        s_vbus = 1'b0;
        cyc(1, 32'h4000_0000, 32'h0, "R8 clear frame");
        for (int j = 0; j < 2*TICK; j++) cyc(0, 0, 32'h0, "R10 no tick without vbus");

        @(posedge clk); #2;
        @(posedge clk); #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule